// File: doc/BRIEF.md
# Decimal Carry-Chain Adder

This block adds two unsigned packed decimal operands of `NDIG` digits each, plus a one-bit carry input. It returns `NDIG` decimal sum digits and a decimal carry out. Each digit nibble holds one value from 0 to 9, and digit 0 is in bits [3:0].

Every digit first forms a plain 5-bit binary sum of its two nibbles. From that digit pair the block derives two flags:

- A pass-through flag, set when the pair totals exactly nine.
- A launch flag, set when the pair totals more than nine.

The flags steer a chain of single-bit 2-to-1 selectors that carry the decimal carries from the low digit to the high digit. A final per-digit stage then corrects the binary sum into a decimal digit. It adds six when that digit sends a carry onward.

The parameter `PG_FORM` selects how the flags are formed:

- `PG_FROM_SUM` decodes them from the 5-bit intermediate sum.
- `PG_FROM_OPERANDS` decodes them from the operand bits, using the 3-bit upper parts of each digit and the low bits.

The parameter `REGISTER_OUT` adds one output register stage, which is cleared by an active-low reset. Without it the block is purely combinational. The block has no states. The only sequential element is the optional output register, which has two conditions: cleared (during reset) and loading (every clock otherwise).

Top module: `bcd_chain_adder`

## Requirements
- R1: For valid decimal operands, the sum digits equal (A + B + carry_in) mod 10^NDIG, and carry_out is 1 exactly when A + B + carry_in reaches 10^NDIG. Here A and B are the decoded decimal values, and digit i has weight 10^i.
- R2: A digit pair totalling exactly 9 passes the incoming carry through unchanged. A pair totalling 10 or more launches a carry regardless of the incoming carry. No digit sets both flags at once.
- R3: The carry into digit i+1 is 1 exactly when x(i) + y(i) + c(i) >= 10. An unbroken run of pairs totalling nine carries c(0) all the way to carry_out.
- R4: Each sum digit is the low four bits of x + y + c(i), plus 6 when that digit's carry out is 1, taken modulo 16.
- R5: `PG_FROM_SUM` and `PG_FROM_OPERANDS` produce identical outputs for every valid operand pair and carry input.
- R6: With REGISTER_OUT = 1, outputs appear one clock after the inputs are sampled. While rst_n is low, the sum digits and carry_out are 0.
- R7: carry_in adds exactly one unit to the least significant digit.
- R8: For valid operands, every output digit is in the range 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset; clears the output register |
| a_digits | input | 4*NDIG | First operand, packed decimal, digit 0 in bits [3:0] |
| b_digits | input | 4*NDIG | Second operand, packed decimal |
| carry_in | input | 1 | Carry into digit 0 |
| sum_digits | output | 4*NDIG | Packed decimal sum |
| carry_out | output | 1 | Decimal carry out of the top digit |

## Verification
An exhaustive sweep of digit 0 over all pairs with both carry inputs separates the plus-six correction from the plain pass-through of the output stage. Operands whose digit pairs all total nine, with carry in 0 and then 1, distinguish a working pass-through flag from one that drops or invents a carry along the whole chain. All-nines plus all-nines with carry in, and zero plus zero, bound the launch flag and the idle case. Random valid operands drive both flag forms side by side against integer addition.

// File: rtl/bcdcc_pkg.sv
package bcdcc_pkg;
    localparam int DIGIT_W = 4;
    localparam int ISUM_W  = DIGIT_W + 1;

    typedef logic [DIGIT_W-1:0] bcd_digit_t;

    typedef enum logic {
        PG_FROM_SUM      = 1'b0,
        PG_FROM_OPERANDS = 1'b1
    } pg_form_e;
endpackage

// File: rtl/bcdcc_digit_front.sv
module bcdcc_digit_front
    import bcdcc_pkg::*;
#(
    parameter pg_form_e FORM = PG_FROM_SUM
) (
    input  bcd_digit_t        x,
    input  bcd_digit_t        y,
    output logic [ISUM_W-1:0] s,
    output logic              p,
    output logic              g
);
    // plain 4-bit binary addition with its carry as bit 4
    assign s = {1'b0, x} + {1'b0, y};

    generate
        if (FORM == PG_FROM_SUM) begin : g_sum_pg
            logic over9;
            assign over9 = s[4] | (s[3] & (s[2] | s[1]));
            assign g     = over9;
            assign p     = s[3] & s[0] & ~over9;
        end else begin : g_opnd_pg
            logic [3:0] hi_sum;
            logic       hi_eq4;
            logic       hi_ge5;
            assign hi_sum = {1'b0, x[3:1]} + {1'b0, y[3:1]};
            assign hi_eq4 = (hi_sum == 4'd4);
            assign hi_ge5 = (hi_sum >= 4'd5);
            assign p      = (x[0] ^ y[0]) & hi_eq4;
            assign g      = hi_ge5 | (hi_eq4 & x[0] & y[0]);
        end
    endgenerate
endmodule

// File: rtl/bcdcc_carry_chain.sv
module bcdcc_carry_chain #(
    parameter int NDIG = 8
) (
    input  logic [NDIG-1:0] p,
    input  logic [NDIG-1:0] g,
    input  logic            cin,
    output logic [NDIG:0]   c
);
    assign c[0] = cin;

    generate
        for (genvar i = 0; i < NDIG; i++) begin : g_link
            // per-digit 2-to-1 selector: pass the incoming carry or take the launch flag
            assign c[i+1] = p[i] ? c[i] : g[i];
        end
    endgenerate
endmodule

// File: rtl/bcdcc_digit_fix.sv
module bcdcc_digit_fix
    import bcdcc_pkg::*;
(
    input  logic [DIGIT_W-1:0] s_low,
    input  logic               c_in_d,
    input  logic               c_out_d,
    output bcd_digit_t         z
);
    logic [DIGIT_W-1:0] corr;

    assign corr = c_out_d ? 4'd6 : 4'd0;
    assign z    = s_low + corr + {3'b000, c_in_d};
endmodule

// File: rtl/bcd_chain_adder.sv
module bcd_chain_adder
    import bcdcc_pkg::*;
#(
    parameter int       NDIG         = 8,
    parameter pg_form_e PG_FORM      = PG_FROM_SUM,
    parameter bit       REGISTER_OUT = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [DIGIT_W*NDIG-1:0] a_digits,
    input  logic [DIGIT_W*NDIG-1:0] b_digits,
    input  logic                    carry_in,
    output logic [DIGIT_W*NDIG-1:0] sum_digits,
    output logic                    carry_out
);
    localparam int VEC_W = DIGIT_W * NDIG;

    logic [ISUM_W-1:0] isum [NDIG];
    logic [NDIG-1:0]   pflag;
    logic [NDIG-1:0]   gflag;
    logic [NDIG:0]     cy;
    logic [VEC_W-1:0]  sum_next;

    generate
        for (genvar i = 0; i < NDIG; i++) begin : g_dig
            bcdcc_digit_front #(.FORM(PG_FORM)) u_front (
                .x (a_digits[DIGIT_W*i +: DIGIT_W]),
                .y (b_digits[DIGIT_W*i +: DIGIT_W]),
                .s (isum[i]),
                .p (pflag[i]),
                .g (gflag[i])
            );
            bcdcc_digit_fix u_fix (
                .s_low   (isum[i][DIGIT_W-1:0]),
                .c_in_d  (cy[i]),
                .c_out_d (cy[i+1]),
                .z       (sum_next[DIGIT_W*i +: DIGIT_W])
            );
        end
    endgenerate

    bcdcc_carry_chain #(.NDIG(NDIG)) u_chain (
        .p   (pflag),
        .g   (gflag),
        .cin (carry_in),
        .c   (cy)
    );

    generate
        if (REGISTER_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sum_digits <= '0;
                    carry_out  <= 1'b0;
                end else begin
                    sum_digits <= sum_next;
                    carry_out  <= cy[NDIG];
                end
            end
        end else begin : g_comb
            assign sum_digits = sum_next;
            assign carry_out  = cy[NDIG];
        end
    endgenerate

    // ---------------- assertions ----------------
    logic in_valid;
    logic nxt_valid;
    always_comb begin
        in_valid  = 1'b1;
        nxt_valid = 1'b1;
        for (int k = 0; k < NDIG; k++) begin
            if (a_digits[DIGIT_W*k +: DIGIT_W] > 4'd9) in_valid = 1'b0;
            if (b_digits[DIGIT_W*k +: DIGIT_W] > 4'd9) in_valid = 1'b0;
            if (sum_next[DIGIT_W*k +: DIGIT_W] > 4'd9) nxt_valid = 1'b0;
        end
    end

    logic seen_edge;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_edge <= 1'b0;
        else        seen_edge <= 1'b1;
    end

    AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> nxt_valid); // R8

    generate
        for (genvar i = 0; i < NDIG; i++) begin : g_chk
            AST_PG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0({pflag[i], gflag[i]})); // R2
            AST_CARRY_MEANING: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |-> (cy[i+1] == (({1'b0, a_digits[DIGIT_W*i +: DIGIT_W]}
                    + {1'b0, b_digits[DIGIT_W*i +: DIGIT_W]} + {4'b0000, cy[i]}) >= 5'd10))); // R3
            AST_HIGH_SUM_CARRIES: assert property (@(posedge clk) disable iff (!rst_n)
                isum[i][DIGIT_W] |-> cy[i+1]); // R4
        end
        if (REGISTER_OUT) begin : g_reg_chk
            AST_REG_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
                seen_edge |-> (sum_digits == $past(sum_next)
                               && carry_out == $past(cy[NDIG]))); // R6
        end
    endgenerate
endmodule

// File: tb/sim_bcd_chain_adder.sv
module sim_bcd_chain_adder;
    import bcdcc_pkg::*;

    localparam int NDIG  = 8;
    localparam int VEC_W = 4 * NDIG;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [VEC_W-1:0] a_in = '0;
    logic [VEC_W-1:0] b_in = '0;
    logic             cin = 1'b0;
    logic [VEC_W-1:0] sum0, sum1;
    logic             co0, co1;

    int vectors = 0;
    int errors  = 0;

    always #4 clk = ~clk; // 125 MHz

    bcd_chain_adder #(.NDIG(NDIG), .PG_FORM(PG_FROM_SUM), .REGISTER_OUT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .a_digits(a_in), .b_digits(b_in),
        .carry_in(cin), .sum_digits(sum0), .carry_out(co0));

    bcd_chain_adder #(.NDIG(NDIG), .PG_FORM(PG_FROM_OPERANDS), .REGISTER_OUT(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .a_digits(a_in), .b_digits(b_in),
        .carry_in(cin), .sum_digits(sum1), .carry_out(co1));

    function automatic longint dec(input logic [VEC_W-1:0] v);
        longint r = 0;
        for (int k = NDIG - 1; k >= 0; k--) r = r * 10 + longint'(v[4*k +: 4]);
        return r;
    endfunction

    function automatic logic [VEC_W-1:0] enc(input longint v);
        logic [VEC_W-1:0] r = '0;
        longint t = v;
        for (int k = 0; k < NDIG; k++) begin
            r[4*k +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    function automatic logic [VEC_W-1:0] rand_bcd();
        logic [VEC_W-1:0] r;
        for (int k = 0; k < NDIG; k++) r[4*k +: 4] = 4'($urandom_range(9));
        return r;
    endfunction

    function automatic logic [VEC_W-1:0] fill(input logic [3:0] d);
        logic [VEC_W-1:0] r;
        for (int k = 0; k < NDIG; k++) r[4*k +: 4] = d;
        return r;
    endfunction

    // apply one vector; registered output is checked at the negedge after the capturing posedge
    task automatic apply(input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b,
                         input logic c, input string tag);
        longint modv = 1;
        longint tot;
        logic [VEC_W-1:0] exp_s;
        logic exp_c;
        bit dig_bad;
        for (int k = 0; k < NDIG; k++) modv = modv * 10;
        @(negedge clk);
        a_in = a; b_in = b; cin = c;
        tot   = dec(a) + dec(b) + longint'(c);
        exp_s = enc(tot % modv);
        exp_c = (tot >= modv);
        @(posedge clk);
        @(negedge clk);
        vectors++;
        dig_bad = 1'b0;
        for (int k = 0; k < NDIG; k++) if (sum0[4*k +: 4] > 4'd9) dig_bad = 1'b1;
        if (sum0 !== exp_s || co0 !== exp_c) begin
            errors++;
            $display("FAIL %s sum-form: got %h/%b expected %h/%b", tag, sum0, co0, exp_s, exp_c);
        end
        if (sum1 !== exp_s || co1 !== exp_c) begin
            errors++;
            $display("FAIL R5 %s operand-form: got %h/%b expected %h/%b", tag, sum1, co1, exp_s, exp_c);
        end
        if (dig_bad) begin
            errors++;
            $display("FAIL R8 digit out of range: got %h expected all digits <= 9", sum0);
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        // R6: reset clears outputs
        a_in = fill(4'd9); b_in = fill(4'd9); cin = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        vectors++;
        if (sum0 !== '0 || co0 !== 1'b0 || sum1 !== '0 || co1 !== 1'b0) begin
            errors++;
            $display("FAIL R6 reset: got %h/%b expected 0/0", sum0, co0);
        end
        rst_n = 1'b1;

        apply('0, '0, 1'b0, "R1 zero");
        apply('0, '0, 1'b1, "R7 carry in only");
        apply(fill(4'd9), '0, 1'b1, "R3 all nines plus carry");
        apply(fill(4'd9), fill(4'd9), 1'b1, "R1 max operands");
        apply(fill(4'd5), fill(4'd4), 1'b0, "R2 pass run no carry");
        apply(fill(4'd5), fill(4'd4), 1'b1, "R2 pass run carry");
        apply(fill(4'd3), fill(4'd6), 1'b1, "R3 pass run carry");
        apply(fill(4'd7), fill(4'd3), 1'b0, "R2 launch every digit");

        // R4: exhaustive low digit with both carry inputs
        for (int x = 0; x < 10; x++)
            for (int y = 0; y < 10; y++)
                for (int c = 0; c < 2; c++)
                    apply(VEC_W'(x), VEC_W'(y), c[0], "R4 digit sweep");

        // R4: same sweep in the top digit, to observe carry_out
        for (int x = 0; x < 10; x++)
            for (int y = 0; y < 10; y++)
                apply(VEC_W'(x) << (4 * (NDIG - 1)), VEC_W'(y) << (4 * (NDIG - 1)),
                      1'b1, "R4 top digit sweep");

        // R1 / R5 random operands
        for (int n = 0; n < 3000; n++)
            apply(rand_bcd(), rand_bcd(), 1'($urandom_range(1)), "R1 random");

        // R6: latency check through a reset pulse mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        vectors++;
        if (sum0 !== '0 || co0 !== 1'b0) begin
            errors++;
            $display("FAIL R6 mid reset: got %h/%b expected 0/0", sum0, co0);
        end
        rst_n = 1'b1;
        apply(enc(64'd12345678), enc(64'd87654321), 1'b1, "R6 after reset");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule